// File: doc/BRIEF.md
# Lockable Round-Robin Victim Selector

This block picks the way to replace on each allocation into a 32-way set-associative data cache with 32-byte lines, and lets software pin lines in place. Every set keeps a lock count and a round-robin pointer. While the lock-mode input is high, an allocation takes the lowest way that is not yet locked and adds it to the locked region, which grows upward from way 0. Ordinary allocations rotate a pointer over the ways above the locked region only, so a pinned line is never chosen for eviction.

The set is taken from the allocation address just above the line offset. The victim way is combinational for the addressed set. The per-set state changes on the clock edge that samples the allocate strobe. A single unlock command releases the locks of every set at once and leaves each pointer where it is. Tag storage, the data array, line fill and any register decode sit outside this block.

Top module: `lockable_rr_victim`

## Requirements
- R1: The set index is address bits [8:5] with the defaults (16 sets, 32-byte lines). Offset bits and bits above the index do not affect which set is used.
- R2: After reset every lock count and pointer is zero. With lock mode low, the victim for any set is way 0.
- R3: An allocation with lock mode high into a set whose lock count L is below 28 selects way L as victim. L then becomes L+1.
- R4: The lock count never exceeds 28, so ways 28 to 31 stay replaceable. A lock-mode allocation into a set with L = 28 acts as a normal allocation and leaves L at 28.
- R5: A normal allocation selects the way under the set's pointer and advances that pointer by one.
- R6: A normal allocation from pointer 31 wraps the pointer to the set's lock count L, not to 0.
- R7: When a locked allocation raises L above the pointer, the pointer moves to the new L. Otherwise the pointer is unchanged.
- R8: The unlock command clears the lock count of every set on one clock edge and leaves all pointers unchanged. It takes precedence over a lock increment in the same cycle, while that cycle's pointer update still applies.
- R9: Allocations to one set change no other set's lock count or pointer.
- R10: victim_valid equals alloc_en, and victim_way reflects the addressed set in the same cycle.
- R11: The victim way is never below the addressed set's lock count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_addr | input | 32 | Address of the line being allocated |
| alloc_en | input | 1 | Allocation strobe; state updates on this edge |
| lock_mode | input | 1 | Lock newly allocated lines when high |
| unlock_all | input | 1 | Clear lock counts of all sets |
| victim_way | output | 5 | Way to replace in the addressed set |
| victim_valid | output | 1 | victim_way is meaningful (allocation requested) |

## Verification
The hardest state to reach is a set that is fully locked, where a lock-mode allocation has to fall back to rotation and the pointer wraps to way 28 rather than way 0. The bench reaches it with a directed run of 28 consecutive lock-mode allocations into one set and then continues past the cap. A second hard case is an unlock issued in the same cycle as a locked allocation. The bench produces it directly, and the next allocation shows that the count was cleared while the pointer still moved.

// File: rtl/lrr_pkg.sv
`timescale 1ns/1ps
package lrr_pkg;
    // Cache geometry shared by all units
    localparam int unsigned WAY_W = 5;
    localparam int unsigned WAYS  = 1 << WAY_W;

    typedef logic [WAY_W-1:0] way_t;

    typedef struct packed {
        way_t lock_cnt;   // ways [0, lock_cnt) are pinned
        way_t rr_ptr;     // next rotation victim, always >= lock_cnt
    } set_state_t;

    typedef enum logic [1:0] {
        ALLOC_IDLE   = 2'd0,
        ALLOC_ROTATE = 2'd1,
        ALLOC_PIN    = 2'd2
    } alloc_kind_t;

    // Advance a rotation pointer, wrapping to the lock boundary
    function automatic way_t rotate_next(input way_t ptr, input way_t floor_way);
        way_t r;
        if (ptr == way_t'(WAYS - 1)) r = floor_way;
        else                         r = ptr + way_t'(1);
        return r;
    endfunction
endpackage

// File: rtl/lrr_index.sv
`timescale 1ns/1ps
module lrr_index #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned SETS       = 16,
    parameter int unsigned LINE_BYTES = 32,
    localparam int unsigned OFFS_W    = $clog2(LINE_BYTES),
    localparam int unsigned SET_W     = $clog2(SETS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SET_W-1:0]  set_idx
);
    logic unused_addr_bits;
    assign unused_addr_bits = ^{addr[ADDR_W-1:OFFS_W+SET_W], addr[OFFS_W-1:0]};
    assign set_idx = addr[OFFS_W +: SET_W];
endmodule

// File: rtl/lrr_policy.sv
`timescale 1ns/1ps
module lrr_policy
    import lrr_pkg::*;
#(
    parameter int unsigned LOCK_LIMIT = 28
) (
    input  set_state_t  cur,
    input  logic        alloc_en,
    input  logic        lock_mode,
    output way_t        victim,
    output alloc_kind_t kind,
    output set_state_t  nxt
);
    localparam way_t LIMIT = way_t'(LOCK_LIMIT);

    logic pin_ok;
    way_t grown;

    assign pin_ok = lock_mode && (cur.lock_cnt < LIMIT);
    assign grown  = cur.lock_cnt + way_t'(1);

    always_comb begin
        nxt = cur;
        if (!alloc_en) begin
            kind = ALLOC_IDLE;
        end else if (pin_ok) begin
            kind         = ALLOC_PIN;
            nxt.lock_cnt = grown;
            if (cur.rr_ptr < grown) nxt.rr_ptr = grown;
        end else begin
            kind       = ALLOC_ROTATE;
            nxt.rr_ptr = rotate_next(cur.rr_ptr, cur.lock_cnt);
        end
    end

    assign victim = pin_ok ? cur.lock_cnt : cur.rr_ptr;
endmodule

// File: rtl/lrr_state_bank.sv
`timescale 1ns/1ps
module lrr_state_bank
    import lrr_pkg::*;
#(
    parameter int unsigned SETS = 16,
    localparam int unsigned SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] idx,
    input  logic             wr_en,
    input  set_state_t       wr_state,
    input  logic             clear_locks,
    output set_state_t       rd_state
);
    set_state_t state_q [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic hit;
        assign hit = wr_en && (idx == SET_W'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                state_q[s] <= '0;
            end else begin
                if (hit) state_q[s].rr_ptr <= wr_state.rr_ptr;
                if (clear_locks)  state_q[s].lock_cnt <= '0;
                else if (hit)     state_q[s].lock_cnt <= wr_state.lock_cnt;
            end
        end
    end

    assign rd_state = state_q[idx];
endmodule

// File: rtl/lockable_rr_victim.sv
`timescale 1ns/1ps
module lockable_rr_victim
    import lrr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned SETS       = 16,
    parameter int unsigned LINE_BYTES = 32,
    parameter int unsigned LOCK_LIMIT = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              alloc_en,
    input  logic              lock_mode,
    input  logic              unlock_all,
    output logic [WAY_W-1:0]  victim_way,
    output logic              victim_valid
);
    localparam int unsigned SET_W = $clog2(SETS);

    logic [SET_W-1:0] set_idx;
    set_state_t       cur_state;
    set_state_t       nxt_state;
    alloc_kind_t      kind;

    lrr_index #(
        .ADDR_W(ADDR_W), .SETS(SETS), .LINE_BYTES(LINE_BYTES)
    ) u_index (
        .addr(alloc_addr), .set_idx(set_idx)
    );

    lrr_state_bank #(.SETS(SETS)) u_bank (
        .clk(clk), .rst(rst), .idx(set_idx),
        .wr_en(kind != ALLOC_IDLE), .wr_state(nxt_state),
        .clear_locks(unlock_all), .rd_state(cur_state)
    );

    lrr_policy #(.LOCK_LIMIT(LOCK_LIMIT)) u_policy (
        .cur(cur_state), .alloc_en(alloc_en), .lock_mode(lock_mode),
        .victim(victim_way), .kind(kind), .nxt(nxt_state)
    );

    assign victim_valid = alloc_en;
endmodule

// File: rtl/lrr_checker.sv
`timescale 1ns/1ps
module lrr_checker
    import lrr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LOCK_LIMIT = 28
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] alloc_addr,
    input logic              alloc_en,
    input logic              lock_mode,
    input logic              unlock_all,
    input logic [WAY_W-1:0]  victim_way,
    input set_state_t        cur_state
);
    localparam way_t LIMIT = way_t'(LOCK_LIMIT);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    a_r11_victim_unlocked: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> victim_way >= cur_state.lock_cnt);

    a_r4_lock_cap: assert property (@(posedge clk) disable iff (rst)
        cur_state.lock_cnt <= LIMIT);

    a_r3_lock_step: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(alloc_en && lock_mode && !unlock_all && cur_state.lock_cnt < LIMIT)
         && $stable(alloc_addr))
        |-> cur_state.lock_cnt == $past(cur_state.lock_cnt) + way_t'(1));

    a_r8_unlock_clears: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(unlock_all)) |-> cur_state.lock_cnt == '0);

    a_r8_ptr_kept: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(unlock_all && !alloc_en) && $stable(alloc_addr))
        |-> cur_state.rr_ptr == $past(cur_state.rr_ptr));

    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(alloc_en && !lock_mode && !unlock_all
                          && cur_state.rr_ptr == way_t'(WAYS - 1))
         && $stable(alloc_addr))
        |-> cur_state.rr_ptr == $past(cur_state.lock_cnt));
endmodule

bind lockable_rr_victim lrr_checker #(
    .ADDR_W(ADDR_W), .LOCK_LIMIT(LOCK_LIMIT)
) u_chk (
    .clk(clk), .rst(rst), .alloc_addr(alloc_addr), .alloc_en(alloc_en),
    .lock_mode(lock_mode), .unlock_all(unlock_all),
    .victim_way(victim_way), .cur_state(cur_state)
);

// File: tb/lockable_rr_victim_bench.sv
`timescale 1ns/1ps
module lockable_rr_victim_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] alloc_addr;
    logic        alloc_en, lock_mode, unlock_all;
    logic [4:0]  victim_way;
    logic        victim_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    lockable_rr_victim u_lockable_rr_victim (
        .clk(clk), .rst(rst), .alloc_addr(alloc_addr), .alloc_en(alloc_en),
        .lock_mode(lock_mode), .unlock_all(unlock_all),
        .victim_way(victim_way), .victim_valid(victim_valid)
    );

    // {set[3:0], lock, unlock, expected victim[4:0]}; every entry allocates
    localparam logic [10:0] VEC [14] = '{
        {4'd0, 1'b0, 1'b0, 5'd0},   // R2/R5
        {4'd0, 1'b0, 1'b0, 5'd1},   // R5
        {4'd0, 1'b1, 1'b0, 5'd0},   // R3
        {4'd0, 1'b1, 1'b0, 5'd1},   // R3
        {4'd0, 1'b1, 1'b0, 5'd2},   // R3, R7 pointer bumped to 3
        {4'd0, 1'b0, 1'b0, 5'd3},   // R7
        {4'd1, 1'b0, 1'b0, 5'd0},   // R9
        {4'd1, 1'b1, 1'b0, 5'd0},   // R3
        {4'd1, 1'b0, 1'b0, 5'd1},   // R5
        {4'd0, 1'b0, 1'b0, 5'd4},   // R9
        {4'd2, 1'b0, 1'b1, 5'd0},   // R8 unlock together with an allocation
        {4'd0, 1'b0, 1'b0, 5'd5},   // R8 pointer kept
        {4'd0, 1'b1, 1'b0, 5'd0},   // R8 lock count cleared
        {4'd1, 1'b1, 1'b0, 5'd0}    // R8 cleared in another set
    };

    function automatic logic [31:0] addr_of(input int s, input int salt);
        return (32'(salt) << 12) | (32'(s) << 5) | 32'h0000_000B;
    endfunction

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one allocation, check the combinational victim, let the edge take it
    task automatic alloc(input int s, input logic lk, input logic ul,
                         input int exp, input string req, input int salt = 0);
        @(negedge clk);
        alloc_addr = addr_of(s, salt);
        lock_mode  = lk;
        unlock_all = ul;
        alloc_en   = 1'b1;
        #2;
        check(victim_way, exp, req);
        check(victim_valid, 1, "R10");
    endtask

    task automatic idle();
        @(negedge clk);
        alloc_en = 1'b0; unlock_all = 1'b0; lock_mode = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; alloc_en = 1'b0; unlock_all = 1'b0; lock_mode = 1'b0;
        alloc_addr = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; alloc_en = 1'b0; lock_mode = 1'b0; unlock_all = 1'b0;
        alloc_addr = '0;
        do_reset();

        // R2: reset state observed without allocating
        for (int s = 0; s < 16; s += 5) begin
            @(negedge clk);
            alloc_addr = addr_of(s, 3);
            #2;
            check(victim_way, 0, "R2");
            check(victim_valid, 0, "R10");
        end

        // Table walk
        for (int i = 0; i < 14; i++) begin
            alloc(int'(VEC[i][10:7]), VEC[i][6], VEC[i][5], int'(VEC[i][4:0]),
                  "R3/R5/R7/R8/R9 table", i);
        end
        idle();

        // R1: upper address bits ignored; set 0 pointer is at 6 after the table
        alloc(0, 1'b0, 1'b0, 6, "R1", 12'hABC);
        alloc(0, 1'b0, 1'b0, 7, "R1", 12'h001);
        // R1: set 8 (address bit 8) is distinct from set 0
        alloc(8, 1'b0, 1'b0, 0, "R1", 0);
        idle();

        // R4/R6/R11: fill set 3 to the lock cap
        do_reset();
        for (int k = 0; k < 28; k++) alloc(3, 1'b1, 1'b0, k, "R3 fill");
        alloc(3, 1'b1, 1'b0, 28, "R4 cap");
        alloc(3, 1'b1, 1'b0, 29, "R4 cap rotate");
        alloc(3, 1'b0, 1'b0, 30, "R5");
        alloc(3, 1'b0, 1'b0, 31, "R5");
        alloc(3, 1'b0, 1'b0, 28, "R6 wrap to lock boundary");
        alloc(3, 1'b1, 1'b0, 29, "R11 never a locked way");
        idle();

        // R6: wrap with no locks goes to way 0
        for (int k = 0; k < 32; k++) alloc(5, 1'b0, 1'b0, k, "R5 sweep");
        alloc(5, 1'b0, 1'b0, 0, "R6 wrap to 0");
        idle();

        // R8: unlock in same cycle as a locked allocation
        alloc(4, 1'b1, 1'b0, 0, "R3");
        alloc(4, 1'b1, 1'b1, 1, "R8 unlock with lock");
        alloc(4, 1'b1, 1'b0, 0, "R8 count cleared");
        alloc(4, 1'b0, 1'b0, 2, "R8/R7 pointer moved");
        idle();

        // R8: pointers kept with unlock alone, set 3 fully locked before
        @(negedge clk);
        unlock_all = 1'b1;
        @(negedge clk);
        unlock_all = 1'b0;
        alloc(3, 1'b0, 1'b0, 30, "R8 pointer kept after unlock");
        alloc(3, 1'b1, 1'b0, 0, "R8 set 3 unlocked");
        idle();

        done = 1'b1;
        finish_run();
    end
endmodule